// File: doc/BRIEF.md
# Infrared Transceiver Mode Controller

This block is the digital control section of a combined infrared data and remote-control transceiver. It watches three slow external lines: a shutdown strobe, the data-transmit line and the remote-control transmit line. From these it decides four things: whether the part is powered down, which receive bandwidth is selected, whether the single-line remote-control drive is armed, and which of the two LED drivers may light. An on-time limiter stops either LED from staying lit when its input is stuck high.

Mode changes reach the block over the shutdown and data pins, which it shares with normal traffic. The block measures how long the shutdown line stays high. A short pulse is a programming strobe. A long pulse is a real power-down. A pulse between the two is discarded and raises an error flag. On the falling edge of a valid strobe, the data line's level selects the bandwidth. If the strobe instead enclosed a complete qualified pulse on the data line, the strobe arms remote-control drive. All thresholds are parameters counted in system-clock cycles. The inputs pass through synchronizers before any decision is made.

Top module: `irx_mode_ctrl`

## Requirements
- R1: After reset, both LED enables and the error flag are 0, the receive-enable is 1, the tri-state flag is 0 and the mode is 2'b00 (bit 0 = high bandwidth, bit 1 = remote-control drive armed).
- R2: A shutdown-line high time of at least SHUT_MIN cycles (default 1500) powers the block down. While down, the tri-state flag is 1, the receive-enable is 0 and both LEDs are off. On entry the mode returns to 2'b00.
- R3: A shutdown-line high time of at most STROBE_MAX cycles (default 250) is a programming strobe. At its falling edge the data-line level is written into mode bit 0 (1 = high bandwidth), and remote-control drive is cleared.
- R4: A strobe's bandwidth selection takes effect only if the data line held its level for at least SETUP_MIN cycles up to the falling edge and keeps that level for HOLD_MIN cycles after it (both default 3). Otherwise the mode is unchanged.
- R5: When not armed and not down, with shutdown low: data line alone high lights the data LED; remote-control line alone high lights the remote-control LED; the receive-enable is 1 exactly when neither LED is lit.
- R6: With both transmit lines high, both LEDs stay off. The two LED enables are never 1 together.
- R7: An LED driven from a line that has been high for LED_MAX cycles (default 2500) is forced off until that line returns low.
- R8: A strobe arms remote-control drive (mode bit 1 = 1, bit 0 kept) when, during it, the data line rose after the shutdown line had been high at least RC_LEAD cycles and then stayed high at least RC_PULSE cycles and fell before the strobe ended (both default 10). A shorter pulse does not arm.
- R9: While armed, the data line lights the remote-control LED and never the data LED; the remote-control line has no effect.
- R10: A shutdown-line high time above STROBE_MAX and below SHUT_MIN leaves the mode unchanged, causes no power-down and raises the error flag for exactly one cycle.
- R11: While the synchronized shutdown line is high, both LED enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_i | input | 1 | Shutdown / programming strobe line |
| tx_ir_i | input | 1 | Data transmit line |
| tx_rc_i | input | 1 | Remote-control transmit line |
| ir_led_en_o | output | 1 | Data LED driver enable |
| rc_led_en_o | output | 1 | Remote-control LED driver enable |
| rx_en_o | output | 1 | Receiver enable |
| rx_hiz_o | output | 1 | Receive output tri-state request |
| mode_o | output | 2 | Bit 0 high bandwidth, bit 1 remote-control drive armed |
| err_o | output | 1 | One-cycle flag for a discarded mid-length shutdown pulse |

## Verification
The bench probes the pulse-length classifier at its limits. A strobe of exactly STROBE_MAX cycles must still program the mode, and one slightly longer must be rejected with an error. If the classifier compares one cycle off, the mode changes or the error flag does not pulse. A 1490-cycle pulse must not power down the part; a comparison that is too loose would tri-state the receiver. Setup and hold violations on the data line are driven so that the wrong level would be latched if the timing checks were missing. Short and long enclosed pulses separate arming from no arming. Stuck-high lines show whether the limiter releases the LED on time and re-lights it after the line drops.

// File: rtl/irx_pkg.sv
package irx_pkg;
   // Classification of a completed shutdown-line high pulse
   typedef enum logic [1:0] {
      FC_NONE   = 2'd0,
      FC_STROBE = 2'd1,
      FC_MID    = 2'd2,
      FC_SHUT   = 2'd3
   } fall_cls_e;

   localparam int MODE_BW_BIT  = 0;
   localparam int MODE_ARM_BIT = 1;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irx_ontime_guard.sv
module irx_ontime_guard #(
   parameter int LED_MAX = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic ok_o
);
   localparam int CW = $clog2(LED_MAX + 1);
   localparam logic [CW-1:0] C_MAX = CW'(LED_MAX);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= '0;
      else if (!line_i)     run_q <= '0;
      else if (run_q != C_MAX) run_q <= run_q + 1'b1;
   end

   // line may drive its LED only while its high run is below the limit
   assign ok_o = line_i && (run_q != C_MAX);
endmodule

// File: rtl/irx_strobe_decoder.sv
module irx_strobe_decoder
   import irx_pkg::*;
#(
   parameter int STROBE_MAX = 250,
   parameter int SHUT_MIN   = 1500,
   parameter int SETUP_MIN  = 3,
   parameter int HOLD_MIN   = 3,
   parameter int RC_LEAD    = 10,
   parameter int RC_PULSE   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sd_i,
   input  logic tir_i,
   output logic shut_o,
   output logic bw_hi_o,
   output logic rc_arm_o,
   output logic err_o
);
   localparam int CW = $clog2(SHUT_MIN + 1);
   localparam int SW = $clog2(SETUP_MIN + 2);
   localparam int HW = $clog2(HOLD_MIN + 1);
   localparam int RW = $clog2(RC_PULSE + 1);
   localparam logic [CW-1:0] C_SHUT    = CW'(SHUT_MIN);
   localparam logic [CW-1:0] C_SHUT_M1 = CW'(SHUT_MIN - 1);
   localparam logic [CW-1:0] C_STROBE  = CW'(STROBE_MAX);
   localparam logic [CW-1:0] C_LEAD    = CW'(RC_LEAD);
   localparam logic [SW-1:0] C_SETUP   = SW'(SETUP_MIN);
   localparam logic [HW-1:0] C_HOLD_M1 = HW'(HOLD_MIN - 1);
   localparam logic [RW-1:0] C_RCP     = RW'(RC_PULSE);

   logic          sd_d, tir_d;
   logic [CW-1:0] sd_cnt;
   logic [SW-1:0] stab_q, stab_now;
   logic          pending, pend_val, pend_rc;
   logic [HW-1:0] hold_cnt;
   logic          rc_qual, rc_ok;
   logic [RW-1:0] rc_len;
   logic          sd_fall, tir_rise, tir_fall;
   fall_cls_e     cls;

   assign sd_fall  = sd_d && !sd_i;
   assign tir_rise = tir_i && !tir_d;
   assign tir_fall = !tir_i && tir_d;

   always_comb begin
      if (tir_i != tir_d)       stab_now = SW'(1);
      else if (stab_q == C_SETUP) stab_now = stab_q;
      else                      stab_now = stab_q + 1'b1;
   end

   always_comb begin
      cls = FC_NONE;
      if (sd_fall) begin
         if (sd_cnt >= C_SHUT)       cls = FC_SHUT;
         else if (sd_cnt > C_STROBE) cls = FC_MID;
         else                        cls = FC_STROBE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_d <= 1'b0; tir_d <= 1'b0; sd_cnt <= '0; stab_q <= '0;
         pending <= 1'b0; pend_val <= 1'b0; pend_rc <= 1'b0; hold_cnt <= '0;
         rc_qual <= 1'b0; rc_ok <= 1'b0; rc_len <= '0;
         shut_o <= 1'b0; bw_hi_o <= 1'b0; rc_arm_o <= 1'b0; err_o <= 1'b0;
      end else begin
         sd_d   <= sd_i;
         tir_d  <= tir_i;
         stab_q <= stab_now;
         err_o  <= (cls == FC_MID);
         if (!sd_i)               sd_cnt <= '0;
         else if (sd_cnt != C_SHUT) sd_cnt <= sd_cnt + 1'b1;
         // qualified data pulse inside a strobe (remote-control arming)
         rc_qual <= sd_i && tir_i && (rc_qual || (tir_rise && sd_cnt >= C_LEAD));
         if (rc_qual && tir_i) begin
            if (rc_len != C_RCP) rc_len <= rc_len + 1'b1;
         end else begin
            rc_len <= '0;
         end
         rc_ok <= sd_i && (rc_ok || (tir_fall && rc_qual && rc_len >= C_RCP));
         if (sd_i && sd_cnt >= C_SHUT_M1) begin
            shut_o   <= 1'b1;
            bw_hi_o  <= 1'b0;
            rc_arm_o <= 1'b0;
            pending  <= 1'b0;
         end else begin
            if (!sd_i) shut_o <= 1'b0;
            if (cls == FC_STROBE && stab_now >= C_SETUP) begin
               pending  <= 1'b1;
               pend_val <= tir_i;
               pend_rc  <= rc_ok;
               hold_cnt <= '0;
            end else if (pending) begin
               if (sd_i || tir_i != pend_val) begin
                  pending <= 1'b0;
               end else if (hold_cnt == C_HOLD_M1) begin
                  pending <= 1'b0;
                  if (pend_rc) begin
                     rc_arm_o <= 1'b1;
                  end else begin
                     bw_hi_o  <= pend_val;
                     rc_arm_o <= 1'b0;
                  end
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/irx_mode_ctrl.sv
module irx_mode_ctrl
   import irx_pkg::*;
#(
   parameter int STROBE_MAX  = 250,
   parameter int SHUT_MIN    = 1500,
   parameter int SETUP_MIN   = 3,
   parameter int HOLD_MIN    = 3,
   parameter int RC_LEAD     = 10,
   parameter int RC_PULSE    = 10,
   parameter int LED_MAX     = 2500,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sd_i,
   input  logic       tx_ir_i,
   input  logic       tx_rc_i,
   output logic       ir_led_en_o,
   output logic       rc_led_en_o,
   output logic       rx_en_o,
   output logic       rx_hiz_o,
   output logic [1:0] mode_o,
   output logic       err_o
);
   localparam int NLINES = 2;

   if (STROBE_MAX >= SHUT_MIN) begin : g_bad_window
      $error("STROBE_MAX must be below SHUT_MIN");
   end
   if (RC_LEAD >= STROBE_MAX) begin : g_bad_lead
      $error("RC_LEAD must be below STROBE_MAX");
   end
   if (SETUP_MIN < 1 || HOLD_MIN < 1 || RC_PULSE < 1 || SHUT_MIN < 2) begin : g_bad_min
      $error("timing minimums must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]        sync_q;
   logic              sd_s, tir_s, trc_s;
   logic [NLINES-1:0] lines, ok;
   logic              shut, bw_hi, rc_arm;
   logic              ir_nx, rc_nx;

   irx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .d_i ({sd_i, tx_ir_i, tx_rc_i}),
      .q_o (sync_q)
   );
   assign {sd_s, tir_s, trc_s} = sync_q;

   irx_strobe_decoder #(
      .STROBE_MAX (STROBE_MAX), .SHUT_MIN (SHUT_MIN),
      .SETUP_MIN  (SETUP_MIN),  .HOLD_MIN (HOLD_MIN),
      .RC_LEAD    (RC_LEAD),    .RC_PULSE (RC_PULSE)
   ) u_dec (
      .clk (clk), .rst_n (rst_n), .sd_i (sd_s), .tir_i (tir_s),
      .shut_o (shut), .bw_hi_o (bw_hi), .rc_arm_o (rc_arm), .err_o (err_o)
   );

   assign lines = {trc_s, tir_s};

   for (genvar g = 0; g < NLINES; g++) begin : g_guard
      irx_ontime_guard #(.LED_MAX(LED_MAX)) u_guard (
         .clk (clk), .rst_n (rst_n), .line_i (lines[g]), .ok_o (ok[g])
      );
   end

   always_comb begin
      ir_nx = 1'b0;
      rc_nx = 1'b0;
      if (!shut && !sd_s) begin
         if (rc_arm) begin
            rc_nx = ok[0];
         end else if (tir_s ^ trc_s) begin
            ir_nx = ok[0];
            rc_nx = ok[1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_led_en_o <= 1'b0;
         rc_led_en_o <= 1'b0;
         rx_en_o     <= 1'b1;
         rx_hiz_o    <= 1'b0;
      end else begin
         ir_led_en_o <= ir_nx;
         rc_led_en_o <= rc_nx;
         rx_en_o     <= !shut && !ir_nx && !rc_nx;
         rx_hiz_o    <= shut;
      end
   end

   always_comb begin
      mode_o               = '0;
      mode_o[MODE_BW_BIT]  = bw_hi;
      mode_o[MODE_ARM_BIT] = rc_arm;
   end
endmodule

// File: rtl/irx_mode_ctrl_chk.sv
module irx_mode_ctrl_chk #(
   parameter int LED_MAX = 2500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ir_led_en_o,
   input logic       rc_led_en_o,
   input logic       rx_en_o,
   input logic       rx_hiz_o,
   input logic [1:0] mode_o,
   input logic       err_o
);
   localparam int RW = $clog2(LED_MAX + 2);
   localparam logic [RW-1:0] C_MAX = RW'(LED_MAX);

   logic [RW-1:0] ir_run, rc_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_run <= '0;
         rc_run <= '0;
      end else begin
         ir_run <= ir_led_en_o ? ((ir_run > C_MAX) ? ir_run : ir_run + 1'b1) : '0;
         rc_run <= rc_led_en_o ? ((rc_run > C_MAX) ? rc_run : rc_run + 1'b1) : '0;
      end
   end

   AST_DOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hiz_o |-> (!ir_led_en_o && !rc_led_en_o && !rx_en_o)); // R2
   AST_DOWN_SIR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hiz_o |-> (mode_o == 2'b00)); // R2
   AST_LED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ir_led_en_o, rc_led_en_o})); // R6
   AST_RX_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en_o |-> (!ir_led_en_o && !rc_led_en_o)); // R5
   AST_IR_ONTIME: assert property (@(posedge clk) disable iff (!rst_n)
      ir_run <= C_MAX); // R7
   AST_RC_ONTIME: assert property (@(posedge clk) disable iff (!rst_n)
      rc_run <= C_MAX); // R7
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R10
   AST_ERR_NO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !rx_hiz_o); // R10
endmodule

bind irx_mode_ctrl irx_mode_ctrl_chk #(.LED_MAX(LED_MAX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ir_led_en_o (ir_led_en_o),
   .rc_led_en_o (rc_led_en_o),
   .rx_en_o     (rx_en_o),
   .rx_hiz_o    (rx_hiz_o),
   .mode_o      (mode_o),
   .err_o       (err_o)
);

// File: tb/irx_mode_ctrl_tb.sv
module irx_mode_ctrl_tb;
   typedef struct {
      string      tag;
      logic       ir;
      logic       rc;
      logic       rx;
      logic       hiz;
      logic [1:0] mode;
      int         errs;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sd = 1'b0, tir = 1'b0, trc = 1'b0;
   logic       ir_led, rc_led, rx_en, rx_hiz, err;
   logic [1:0] mode;

   int   checks = 0;
   int   failures = 0;
   int   err_seen = 0;
   int   exp_errs = 0;
   exp_t sb[$];
   exp_t cur;

   always #4 clk = ~clk;

   irx_mode_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .sd_i (sd), .tx_ir_i (tir), .tx_rc_i (trc),
      .ir_led_en_o (ir_led), .rc_led_en_o (rc_led), .rx_en_o (rx_en),
      .rx_hiz_o (rx_hiz), .mode_o (mode), .err_o (err)
   );

   // error pulse counter
   always @(negedge clk) if (rst_n && err) err_seen++;

   // monitor: pops expected items and compares
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         checks++;
         if (ir_led !== cur.ir || rc_led !== cur.rc || rx_en !== cur.rx ||
             rx_hiz !== cur.hiz || mode !== cur.mode || err_seen != cur.errs) begin
            failures++;
            $display("FAIL %s: actual ir=%b rc=%b rx=%b hiz=%b mode=%b errs=%0d expected ir=%b rc=%b rx=%b hiz=%b mode=%b errs=%0d",
                     cur.tag, ir_led, rc_led, rx_en, rx_hiz, mode, err_seen,
                     cur.ir, cur.rc, cur.rx, cur.hiz, cur.mode, cur.errs);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_st(input string tag, input logic e_ir, input logic e_rc,
                            input logic e_rx, input logic e_hiz, input logic [1:0] e_mode);
      exp_t it;
      cyc(6);
      it.tag = tag; it.ir = e_ir; it.rc = e_rc; it.rx = e_rx;
      it.hiz = e_hiz; it.mode = e_mode; it.errs = exp_errs;
      sb.push_back(it);
      while (sb.size() != 0) @(posedge clk);
      #1;
   endtask

   task automatic pulse_sd(input int n);
      sd = 1'b1;
      cyc(n);
      sd = 1'b0;
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      cyc(3);
      #1;
      expect_st("R1 reset state", 0, 0, 1, 0, 2'b00);
      rst_n = 1'b1;
      cyc(2);

      // R5 two-line truth table
      tir = 1; expect_st("R5 data line lights data LED", 1, 0, 0, 0, 2'b00);
      tir = 0; trc = 1; expect_st("R5 rc line lights rc LED", 0, 1, 0, 0, 2'b00);
      tir = 1; expect_st("R6 both lines high keeps LEDs off", 0, 0, 1, 0, 2'b00);
      tir = 0; trc = 0; expect_st("R5 idle enables receiver", 0, 0, 1, 0, 2'b00);

      // R3 high-bandwidth strobe, R11 dark while strobe high
      sd = 1; cyc(20); tir = 1; cyc(30);
      expect_st("R11 LEDs dark while strobe high", 0, 0, 1, 0, 2'b00);
      cyc(40); sd = 0; cyc(10); tir = 0;
      expect_st("R3 strobe selects high bandwidth", 0, 0, 1, 0, 2'b01);

      // R3 low-bandwidth strobe
      pulse_sd(100); cyc(10);
      expect_st("R3 strobe selects low bandwidth", 0, 0, 1, 0, 2'b00);

      // R3 boundary: exactly STROBE_MAX still programs
      tir = 1; cyc(5); pulse_sd(250); cyc(10); tir = 0;
      expect_st("R3 strobe of STROBE_MAX cycles accepted", 0, 0, 1, 0, 2'b01);

      // R10 just over STROBE_MAX is discarded with error
      pulse_sd(255); cyc(10); exp_errs++;
      expect_st("R10 pulse over STROBE_MAX discarded", 0, 0, 1, 0, 2'b01);
      pulse_sd(800); cyc(10); exp_errs++;
      expect_st("R10 mid pulse ignored with error", 0, 0, 1, 0, 2'b01);

      // R4 setup violation: data drops one cycle before the falling edge
      sd = 1; tir = 1; cyc(100); tir = 0; cyc(1); sd = 0; cyc(10);
      expect_st("R4 setup violation ignored", 0, 0, 1, 0, 2'b01);
      // R4 hold violation: data rises one cycle after the falling edge
      sd = 1; cyc(100); sd = 0; cyc(1); tir = 1; cyc(10); tir = 0;
      expect_st("R4 hold violation ignored", 0, 0, 1, 0, 2'b01);

      // R8 arming sequence
      sd = 1; cyc(20); tir = 1; cyc(15); tir = 0; cyc(10); sd = 0; cyc(10);
      expect_st("R8 enclosed pulse arms rc drive", 0, 0, 1, 0, 2'b11);

      // R9 armed routing
      tir = 1; expect_st("R9 armed data line lights rc LED", 0, 1, 0, 0, 2'b11);
      tir = 0; trc = 1; expect_st("R9 armed rc line has no effect", 0, 0, 1, 0, 2'b11);
      trc = 0;

      // R7 stuck data line while armed
      tir = 1; cyc(100);
      expect_st("R7 rc LED on before limit", 0, 1, 0, 0, 2'b11);
      cyc(2450);
      expect_st("R7 rc LED forced off after limit", 0, 0, 1, 0, 2'b11);
      tir = 0; cyc(4); tir = 1;
      expect_st("R7 LED relit after line returns low", 0, 1, 0, 0, 2'b11);
      tir = 0; cyc(4);

      // R2 real shutdown
      sd = 1; cyc(1550);
      expect_st("R2 shutdown state", 0, 0, 0, 1, 2'b00);
      cyc(50); sd = 0; cyc(10);
      expect_st("R2 after shutdown mode is low bandwidth", 0, 0, 1, 0, 2'b00);

      // R10 boundary below SHUT_MIN
      tir = 1; cyc(5); pulse_sd(100); cyc(10); tir = 0;
      expect_st("R3 reselect high bandwidth", 0, 0, 1, 0, 2'b01);
      pulse_sd(1490); cyc(10); exp_errs++;
      expect_st("R10 pulse just below SHUT_MIN no shutdown", 0, 0, 1, 0, 2'b01);

      // R8 short enclosed pulse does not arm; strobe acts as low-bandwidth select
      sd = 1; cyc(20); tir = 1; cyc(5); tir = 0; cyc(10); sd = 0; cyc(10);
      expect_st("R8 short pulse does not arm", 0, 0, 1, 0, 2'b00);

      // R7 stuck rc line, unarmed
      trc = 1; cyc(100);
      expect_st("R7 rc line lit before limit", 0, 1, 0, 0, 2'b00);
      cyc(2450);
      expect_st("R7 rc line forced off after limit", 0, 0, 1, 0, 2'b00);
      trc = 0;

      report();
      $finish;
   end
endmodule